// File: doc/BRIEF.md
# Open-Bus I/O Read Latch

This block sits on the read path between an 8-bit processor and the peripherals that answer inside a 13-bit I/O window. Many peripheral registers drive only some of the data lines. The lines they leave undriven keep whatever value the bus carried last. The block models that effect with a byte-wide hold latch. On each read it merges the raw peripheral byte with the latch under a mask chosen by the address. It returns the merged byte and stores it as the new latch value.

Only one address band uses the merge. Reads outside that band return the raw byte unchanged and leave the latch alone. The peripherals are outside the block. For each peripheral region the block gives a one-cycle read strobe, so that a peripheral can apply a read side effect exactly once. One extra strobe marks a read of the interrupt status register, which the interrupt controller clears in the same access. Writes do not pass through this block and cannot change the latch.

A read is a single-cycle access. With `rd_en` high, `rd_data` is combinational in that cycle, and the latch takes the merged byte at the closing clock edge. When no read is in progress, `rd_data` shows the latch contents.

Top module: `iobus_hold_latch`

## Requirements
- R1: After reset the latch holds 0x00, so `rd_data` reads 0x00 while `rd_en` is low.
- R2: A read at an address below 0x0800 or at or above 0x1800 returns `raw_data` unchanged and leaves the latch unchanged.
- R3: A read at an address from 0x0800 to 0x17FF returns raw_data OR (latch AND NOT mask), and that byte becomes the latch value at the next clock edge.
- R4: In the sound region (0x0800–0x0BFF), address bits 3:0 select the mask. Values 0 to 9 give 0x03, 0xFF, 0xFF, 0x0F, 0xDF, 0xFF, 0x1F, 0x9F, 0xFF, 0x83. Values 10 to 15 give 0xFF.
- R5: In the timer region (0x0C00–0x0FFF), the mask is 0x7F when address bit 0 is 0 and 0x01 when it is 1.
- R6: In the joypad region (0x1000–0x13FF), the mask is 0xFF.
- R7: In the interrupt region (0x1400–0x17FF), address bits 1:0 select the mask: 0 gives 0xFF, 1 gives 0xFF, 2 gives 0x03 and 3 gives 0x03.
- R8: While `rd_en` is low, the latch keeps its value and `rd_data` shows it, whatever `rd_addr` and `raw_data` do.
- R9: `rd_strobe` bit 0 (sound), bit 1 (timer), bit 2 (joypad) and bit 3 (interrupt) is high exactly in the cycle of a read inside that region. Outside the band every bit stays low, and no two bits are ever high together.
- R10: `irq_stat_clr` is high exactly in the cycle of a read in the interrupt region whose address bits 3:0 equal 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read access in this cycle |
| rd_addr | input | 13 | I/O window address of the read |
| raw_data | input | 8 | Byte driven by the addressed peripheral |
| rd_data | output | 8 | Byte returned to the processor (latch value when idle) |
| rd_strobe | output | 4 | One-cycle read strobe per region: sound, timer, joypad, interrupt |
| irq_stat_clr | output | 1 | Read of the interrupt status register; the status is to be cleared |

## Verification
Two functions can act in the same cycle: the combinational merge that uses the old latch value, and the latch update that stores the merged byte at the closing edge. The bench provokes this with back-to-back reads on successive cycles. Each read's expected byte depends on the value the previous read left behind. It sweeps every address of the window three times, with varying, all-zero and all-one raw data. Between reads it drops `rd_en` and compares `rd_data` with a latch that the bench models arithmetically, so an update landing one cycle early or late, or leaking from an out-of-band read, shows as a mismatch.

// File: rtl/iol_pkg.sv
package iol_pkg;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_SOUND = 3'd1,
        RG_TIMER = 3'd2,
        RG_PAD   = 3'd3,
        RG_IRQ   = 3'd4
    } region_e;

    localparam int NUM_REGIONS = 4;

endpackage

// File: rtl/iol_decode.sv
module iol_decode
    import iol_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              in_band,
    output logic [DATA_W-1:0] mask
);
    localparam int REG_LSB = 10;
    localparam int SEL_W   = ADDR_W - REG_LSB;

    logic [SEL_W-1:0] sel;
    logic [7:0]       mask8;

    assign sel = addr[ADDR_W-1:REG_LSB];

    always_comb begin
        case (sel)
            SEL_W'(2): region = RG_SOUND;
            SEL_W'(3): region = RG_TIMER;
            SEL_W'(4): region = RG_PAD;
            SEL_W'(5): region = RG_IRQ;
            default:   region = RG_NONE;
        endcase
    end

    assign in_band = (region != RG_NONE);

    always_comb begin
        mask8 = 8'hFF;
        unique case (region)
            RG_SOUND: begin
                case (addr[3:0])
                    4'h0:    mask8 = 8'h03;
                    4'h3:    mask8 = 8'h0F;
                    4'h4:    mask8 = 8'hDF;
                    4'h6:    mask8 = 8'h1F;
                    4'h7:    mask8 = 8'h9F;
                    4'h9:    mask8 = 8'h83;
                    default: mask8 = 8'hFF;
                endcase
            end
            RG_TIMER: mask8 = addr[0] ? 8'h01 : 8'h7F;
            RG_PAD:   mask8 = 8'hFF;
            RG_IRQ:   mask8 = addr[1] ? 8'h03 : 8'hFF;
            default:  mask8 = 8'hFF;
        endcase
    end

    generate
        if (DATA_W > 8) begin : g_wide
            assign mask = {{(DATA_W-8){1'b1}}, mask8};
        end else begin : g_narrow
            assign mask = mask8[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/iol_strobe.sv
module iol_strobe
    import iol_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  region_e                region,
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_REGIONS-1:0] strobe,
    output logic                   stat_clr
);
    localparam logic [3:0] STAT_OFS = 4'h3;

    generate
        for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_stb
            assign strobe[i] = rd_en && (region == region_e'(i + 1));
        end
    endgenerate

    assign stat_clr = strobe[NUM_REGIONS-1] && (addr[3:0] == STAT_OFS);

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    assert_strobe_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (strobe == '0));

    assert_clr_in_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> strobe[NUM_REGIONS-1]);

endmodule

// File: rtl/iol_latch.sv
module iol_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              in_band,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
    } state_t;

    state_t state_d, state_q;
    logic [DATA_W-1:0] merged;

    always_comb begin
        state_d = state_q;
        merged  = raw | (state_q.hold & ~mask);
        if (!rd_en) begin
            rd_data = state_q.hold;
        end else if (in_band) begin
            rd_data      = merged;
            state_d.hold = merged;
        end else begin
            rd_data = raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(state_q.hold));

    assert_hold_outband_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_band) |=> $stable(state_q.hold));

    assert_update_from_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_band) |=> (state_q.hold == $past(rd_data)));

    assert_driven_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_band) |-> ((rd_data & mask) == (raw & mask)));

endmodule

// File: rtl/iobus_hold_latch.sv
module iobus_hold_latch
    import iol_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [DATA_W-1:0]      raw_data,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NUM_REGIONS-1:0] rd_strobe,
    output logic                   irq_stat_clr
);
    region_e           region;
    logic              in_band;
    logic [DATA_W-1:0] mask;

    iol_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .addr    (rd_addr),
        .region  (region),
        .in_band (in_band),
        .mask    (mask)
    );

    iol_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .in_band (in_band),
        .mask    (mask),
        .raw     (raw_data),
        .rd_data (rd_data)
    );

    iol_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .region   (region),
        .addr     (rd_addr),
        .strobe   (rd_strobe),
        .stat_clr (irq_stat_clr)
    );

    assert_outband_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_strobe == '0)) |-> (rd_data == raw_data));

endmodule

// File: tb/test_iobus_hold_latch.sv
module test_iobus_hold_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [12:0] rd_addr = '0;
    logic [7:0]  raw_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  rd_strobe;
    logic        irq_stat_clr;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iobus_hold_latch i_iobus_hold_latch (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .raw_data(raw_data), .rd_data(rd_data), .rd_strobe(rd_strobe),
        .irq_stat_clr(irq_stat_clr)
    );

    function automatic logic [7:0] exp_mask(input int a);
        int r = a >> 10;
        int lo = a & 15;
        if (r == 2) begin
            case (lo)
                0: return 8'h03;
                3: return 8'h0F;
                4: return 8'hDF;
                6: return 8'h1F;
                7: return 8'h9F;
                9: return 8'h83;
                default: return 8'hFF;
            endcase
        end
        if (r == 3) return (a & 1) ? 8'h01 : 8'h7F;
        if (r == 5) return ((a & 3) >= 2) ? 8'h03 : 8'hFF;
        return 8'hFF;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_read(input int a, input logic [7:0] raw);
        int r = a >> 10;
        bit band = (a >= 'h0800) && (a < 'h1800);
        logic [7:0] exp;
        logic [3:0] exp_stb;
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 13'(a);
        raw_data = raw;
        #1;
        exp = band ? (raw | (model & ~exp_mask(a))) : raw;
        exp_stb = band ? 4'(1 << (r - 2)) : 4'h0;
        // R2 outside band, R3 merge, R4-R7 masks by region
        if (!band) check8("R2", rd_data, exp);
        else if (r == 2) check8("R4/R3", rd_data, exp);
        else if (r == 3) check8("R5/R3", rd_data, exp);
        else if (r == 4) check8("R6/R3", rd_data, exp);
        else check8("R7/R3", rd_data, exp);
        check8("R9", {4'h0, rd_strobe}, {4'h0, exp_stb});
        check8("R10", {7'h0, irq_stat_clr}, {7'h0, (r == 5) && ((a & 15) == 3)});
        if (band) model = exp;
    endtask

    task automatic idle_check(input logic [7:0] noise);
        @(negedge clk);
        rd_en = 1'b0;
        rd_addr = 13'(noise * 29);
        raw_data = noise;
        #1;
        check8("R8", rd_data, model);
        check8("R9", {4'h0, rd_strobe}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check8("R1", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check8("R1", rd_data, 8'h00);
        for (int pass = 0; pass < 3; pass++) begin
            for (int a = 0; a < 8192; a++) begin
                logic [7:0] raw;
                if (pass == 0) raw = 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
                else if (pass == 1) raw = 8'h00;
                else raw = 8'hFF;
                do_read(a, raw);
                if ((a & 255) == 255) idle_check(8'(a));
            end
            // R2: seed latch, then out-of-band read must leave it untouched
            do_read('h1000, 8'hA5);
            do_read('h0400, 8'h3C);
            idle_check(8'h77);
            do_read('h1800, 8'hC3);
            idle_check(8'h11);
        end
        // back-to-back merges on consecutive cycles (R3)
        do_read('h1000, 8'hF0);
        do_read('h0800, 8'h01);
        do_read('h0C01, 8'h00);
        do_read('h1403, 8'h02);
        idle_check(8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule